// File: doc/BRIEF.md
# Blowfish Round Engine with Two-Port S-box Memory

This block encrypts one 64-bit block with the sixteen-round Blowfish Feistel network. The key material is loaded through a simple write port before use: an 18-word subkey array and four 256-entry, 32-bit substitution tables. The four tables share one memory that offers two synchronous reads per clock. The four table lookups of each round therefore split into two pairs. Both reads of a pair return data in the cycle after their addresses are issued.

A host presents the two 32-bit halves with a one-cycle `start` pulse. The engine runs the rounds and the final whitening, then raises `done` for one cycle with the result on `outL`/`outR`. The `twoRound` input, sampled with `start`, selects between two schedules:
- **Three-cycle mode** takes three cycles per round and swaps the halves every round.
- **Paired mode** takes four cycles per two rounds. It never swaps the halves physically. Each half in turn becomes the working side, and the finished F value is folded in during the next subkey step.

The two schedules give bit-identical results.

Top module: `bf_round_engine`

## Requirements
- R1: The result equals Blowfish encryption. For i = 0..15: L ^= P[i]; R ^= F(L); swap. Then undo the last swap and apply R ^= P[16], L ^= P[17]. Here F(x) = ((S0[x[31:24]] + S1[x[23:16]]) ^ S2[x[15:8]]) + S3[x[7:0]], with sums taken modulo 2^32. The output is `outL` = L and `outR` = R.
- R2: Load port addressing works as follows. With `ldEn`=1 and `ldSel`=0, `ldData` is written to table `ldAddr[9:8]` at entry `ldAddr[7:0]`. With `ldSel`=1, `ldData` is written to subkey `P[ldAddr[4:0]]` (0..17).
- R3: In three-cycle mode (`twoRound`=0), `done` is first high after the 49th rising edge that follows the edge accepting `start`. This covers 48 round cycles and one output cycle.
- R4: In paired mode (`twoRound`=1), `done` is first high after the 33rd rising edge that follows the edge accepting `start`. This covers 32 round cycles and one output cycle.
- R5: Both modes give the same output for the same input and key material.
- R6: `done` is high for exactly one cycle. `outL`/`outR` keep their value until the next result is produced.
- R7: A `start` pulse while a block is in progress is ignored. The running block completes with its own result and timing, and no second `done` follows.
- R8: After reset, `done`, `outL` and `outR` are 0.
- R9: When all tables and subkeys are zero, the output is the input with its halves exchanged (`outL` = `inR`, `outR` = `inL`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; honoured only when idle |
| twoRound | input | 1 | Schedule select, sampled with start: 1 = four cycles per two rounds |
| inL | input | 32 | Left input half |
| inR | input | 32 | Right input half |
| ldEn | input | 1 | Key material write enable |
| ldSel | input | 1 | 0 = table entry, 1 = subkey |
| ldAddr | input | 10 | Table select and entry, or subkey index in bits 4:0 |
| ldData | input | 32 | Word to write |
| done | output | 1 | One-cycle result strobe |
| outL | output | 32 | Left result half |
| outR | output | 32 | Right result half |

## Verification
Every cycle, the assertions check the following:
- The control strobes are mutually exclusive.
- The round index stays within bounds.
- `done` is a single-cycle pulse that only follows an output cycle.
- The outputs hold between results.
- A counter in the control confirms that exactly 48 or 32 round cycles elapse before the output step.

Arithmetic correctness of the F function, the table addressing and the final whitening can only be shown by the bench. It compares each result with a behavioural model over several key sets. The bench also confirms that both schedules agree and checks that a mid-run start is ignored.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int P_IDX_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A,
    ST_B,
    ST_C,
    ST_W
  } bfState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               load;   // capture input halves
    logic               stepA;  // subkey XOR, issue first read pair
    logic               stepB;  // sum first pair, issue second read pair
    logic               stepC;  // finish F, XOR into other half, swap
    logic               stepW;  // whitening, register result
    logic               side;   // working half: 0 = L, 1 = R
    logic               fold;   // fold pending F into working half in stepA
    logic               wFold;  // fold pending F into L in stepW
    logic [P_IDX_W-1:0] pIdx;   // subkey index for stepA
  } bfCtl_t;
endpackage

// File: rtl/bf_keymem.sv
module bf_keymem #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int N_BOX   = 4,
  parameter int N_P     = 18,
  localparam int BOX_W  = $clog2(N_BOX),
  localparam int ADDR_W = BOX_W + IDX_W,
  localparam int DEPTH  = N_BOX << IDX_W,
  localparam int PI_W   = $clog2(N_P)
) (
  input  logic                          clk,
  input  logic                          sWe,
  input  logic [ADDR_W-1:0]             sWAddr,
  input  logic                          pWe,
  input  logic [PI_W-1:0]               pWIdx,
  input  logic [WORD_W-1:0]             wData,
  input  logic [1:0][ADDR_W-1:0]        rdAddr,
  output logic [1:0][WORD_W-1:0]        rdData,
  input  logic [PI_W-1:0]               pIdx,
  output logic [WORD_W-1:0]             pRound,
  output logic [WORD_W-1:0]             pLo,
  output logic [WORD_W-1:0]             pHi
);
  logic [WORD_W-1:0] sMem [DEPTH];
  logic [WORD_W-1:0] pArr [N_P];

  always_ff @(posedge clk) begin
    if (sWe) sMem[sWAddr] <= wData;
    if (pWe) pArr[pWIdx] <= wData;
  end

  // Two synchronous read ports, one cycle latency
  for (genvar g = 0; g < 2; g++) begin : g_rdPort
    always_ff @(posedge clk) rdData[g] <= sMem[rdAddr[g]];
  end

  assign pRound = pArr[pIdx];
  assign pLo    = pArr[N_P-2];
  assign pHi    = pArr[N_P-1];
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
#(
  parameter int ROUNDS = 16,
  localparam int CYC_W = $clog2(3*ROUNDS + 1) + 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   twoRound,
  output bfCtl_t ctl,
  output logic   done
);
  localparam logic [P_IDX_W-1:0] LAST = P_IDX_W'(ROUNDS - 1);

  bfState_e           st;
  logic [P_IDX_W-1:0] rnd;
  logic               mode;
  logic               side;
  logic [CYC_W-1:0]   cyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      rnd  <= '0;
      mode <= 1'b0;
      side <= 1'b0;
      done <= 1'b0;
      cyc  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_A;
          rnd  <= '0;
          mode <= twoRound;
          side <= 1'b0;
          cyc  <= '0;
        end
        ST_A: begin
          st  <= ST_B;
          cyc <= cyc + 1'b1;
        end
        ST_B: begin
          cyc <= cyc + 1'b1;
          if (mode) begin
            side <= ~side;
            if (rnd == LAST) st <= ST_W;
            else begin
              rnd <= rnd + 1'b1;
              st  <= ST_A;
            end
          end else begin
            st <= ST_C;
          end
        end
        ST_C: begin
          cyc <= cyc + 1'b1;
          if (rnd == LAST) st <= ST_W;
          else begin
            rnd <= rnd + 1'b1;
            st  <= ST_A;
          end
        end
        ST_W: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.load  = (st == ST_IDLE) && start;
    ctl.stepA = (st == ST_A);
    ctl.stepB = (st == ST_B);
    ctl.stepC = (st == ST_C);
    ctl.stepW = (st == ST_W);
    ctl.side  = side;
    ctl.fold  = mode && (rnd != '0);
    ctl.wFold = mode;
    ctl.pIdx  = rnd;
  end

  // R6: result strobe lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: at most one step strobe per cycle
  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.stepA, ctl.stepB, ctl.stepC, ctl.stepW}));

  // R1: round index stays within the subkey range
  p_round_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    rnd <= LAST);

  // R3 / R4: round-cycle budget per schedule
  p_cycle_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepW |-> (cyc == (mode ? CYC_W'(2*ROUNDS) : CYC_W'(3*ROUNDS))));

  // R7: start during a block does not restart the round index
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_B && !mode && start) |=> (st == ST_C));
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import bf_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int N_BOX   = 4,
  localparam int BOX_W  = $clog2(N_BOX),
  localparam int ADDR_W = BOX_W + IDX_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bfCtl_t                 ctl,
  input  logic [WORD_W-1:0]      inL,
  input  logic [WORD_W-1:0]      inR,
  input  logic [1:0][WORD_W-1:0] rdData,
  input  logic [WORD_W-1:0]      pRound,
  input  logic [WORD_W-1:0]      pLo,
  input  logic [WORD_W-1:0]      pHi,
  output logic [1:0][ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0]      outL,
  output logic [WORD_W-1:0]      outR
);
  logic [WORD_W-1:0] regL, regR, sumAB;
  logic [WORD_W-1:0] hSel, fVal, xVal;

  assign hSel = ctl.side ? regR : regL;
  // Completes F from the held first-pair sum and the second-pair data
  assign fVal = (sumAB ^ rdData[0]) + rdData[1];
  assign xVal = hSel ^ pRound ^ (ctl.fold ? fVal : '0);

  always_comb begin
    if (ctl.stepB) begin
      rdAddr[0] = {BOX_W'(2), hSel[2*IDX_W-1 -: IDX_W]};
      rdAddr[1] = {BOX_W'(3), hSel[IDX_W-1:0]};
    end else begin
      rdAddr[0] = {BOX_W'(0), xVal[WORD_W-1 -: IDX_W]};
      rdAddr[1] = {BOX_W'(1), xVal[WORD_W-IDX_W-1 -: IDX_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regL  <= '0;
      regR  <= '0;
      sumAB <= '0;
      outL  <= '0;
      outR  <= '0;
    end else begin
      if (ctl.load) begin
        regL <= inL;
        regR <= inR;
      end
      if (ctl.stepA) begin
        if (ctl.side) regR <= xVal;
        else          regL <= xVal;
      end
      if (ctl.stepB) sumAB <= rdData[0] + rdData[1];
      if (ctl.stepC) begin
        regL <= regR ^ fVal;
        regR <= regL;
      end
      if (ctl.stepW) begin
        outL <= regR ^ pHi;
        outR <= regL ^ (ctl.wFold ? fVal : '0) ^ pLo;
      end
    end
  end

  // R6: result holds outside the output step
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stepW |=> $stable({outL, outR}));
endmodule

// File: rtl/bf_round_engine.sv
module bf_round_engine
  import bf_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int N_BOX   = 4,
  parameter int ROUNDS  = 16,
  localparam int N_P    = ROUNDS + 2,
  localparam int BOX_W  = $clog2(N_BOX),
  localparam int ADDR_W = BOX_W + IDX_W,
  localparam int PI_W   = $clog2(N_P)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              twoRound,
  input  logic [WORD_W-1:0] inL,
  input  logic [WORD_W-1:0] inR,
  input  logic              ldEn,
  input  logic              ldSel,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [WORD_W-1:0] ldData,
  output logic              done,
  output logic [WORD_W-1:0] outL,
  output logic [WORD_W-1:0] outR
);
  bfCtl_t                 ctl;
  logic [1:0][ADDR_W-1:0] rdAddr;
  logic [1:0][WORD_W-1:0] rdData;
  logic [WORD_W-1:0]      pRound, pLo, pHi;

  bf_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .twoRound(twoRound),
    .ctl(ctl), .done(done)
  );

  bf_keymem #(.WORD_W(WORD_W), .IDX_W(IDX_W), .N_BOX(N_BOX), .N_P(N_P)) u_mem (
    .clk(clk),
    .sWe(ldEn && !ldSel), .sWAddr(ldAddr),
    .pWe(ldEn && ldSel), .pWIdx(ldAddr[PI_W-1:0]),
    .wData(ldData),
    .rdAddr(rdAddr), .rdData(rdData),
    .pIdx(ctl.pIdx[PI_W-1:0]), .pRound(pRound), .pLo(pLo), .pHi(pHi)
  );

  bf_datapath #(.WORD_W(WORD_W), .IDX_W(IDX_W), .N_BOX(N_BOX)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inL(inL), .inR(inR),
    .rdData(rdData), .pRound(pRound), .pLo(pLo), .pHi(pHi),
    .rdAddr(rdAddr), .outL(outL), .outR(outR)
  );

  // R3: a result strobe only follows an output step
  p_done_after_w_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(ctl.stepW));
endmodule

// File: tb/test_bf_round_engine.sv
module test_bf_round_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        twoRound = 1'b0;
  logic [31:0] inL = '0, inR = '0;
  logic        ldEn = 1'b0, ldSel = 1'b0;
  logic [9:0]  ldAddr = '0;
  logic [31:0] ldData = '0;
  logic        done;
  logic [31:0] outL, outR;

  int nChk = 0, nFail = 0;

  bf_round_engine i_bf_round_engine (
    .clk(clk), .rstN(rstN), .start(start), .twoRound(twoRound),
    .inL(inL), .inR(inR), .ldEn(ldEn), .ldSel(ldSel), .ldAddr(ldAddr),
    .ldData(ldData), .done(done), .outL(outL), .outR(outR)
  );

  always #5 clk = ~clk;

  logic [31:0] sb [4][256];
  logic [31:0] pa [18];

  localparam logic [63:0] VEC [4] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF,
    64'hDEAD_BEEF_0BAD_F00D
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run hung, act=running exp=finished");
    summary();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fRef(input logic [31:0] x);
    return ((sb[0][x[31:24]] + sb[1][x[23:16]]) ^ sb[2][x[15:8]]) + sb[3][x[7:0]];
  endfunction

  function automatic logic [63:0] encRef(input logic [63:0] blk);
    logic [31:0] l = blk[63:32], r = blk[31:0], t;
    for (int i = 0; i < 16; i++) begin
      l = l ^ pa[i];
      r = r ^ fRef(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ pa[16];
    l = l ^ pa[17];
    return {l, r};
  endfunction

  task automatic wr(input logic sel, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldSel = sel; ldAddr = a; ldData = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic loadKeys(input logic [31:0] seed, input bit zero);
    logic [31:0] s = seed;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 256; i++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        sb[b][i] = zero ? '0 : s;
        wr(1'b0, {b[1:0], i[7:0]}, sb[b][i]);
      end
    for (int i = 0; i < 18; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      pa[i] = zero ? '0 : s;
      wr(1'b1, 10'(i), pa[i]);
    end
  endtask

  // Runs one block; returns result and edge count to done
  task automatic runBlk(input logic m, input logic [63:0] blk, input int midStart,
                        output logic [63:0] res, output int edges);
    @(negedge clk);
    start = 1'b1; twoRound = m; inL = blk[63:32]; inR = blk[31:0];
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (midStart != 0 && edges == midStart) begin
        start = 1'b1; inL = ~inL; inR = ~inR; twoRound = ~m;
      end else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
    res = {outL, outR};
  endtask

  initial begin : main
    logic [63:0] res, res2, exp;
    int edges;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset done", {63'd0, done}, 64'd0);
    chk("R8 reset out", {outL, outR}, 64'd0);
    rstN = 1'b1;

    loadKeys(32'h1357_9BDF, 1'b0);
    foreach (VEC[v]) begin
      exp = encRef(VEC[v]);
      runBlk(1'b0, VEC[v], 0, res, edges);
      chk("R1 three-cycle result", res, exp);
      chk("R3 three-cycle latency", 64'(edges), 64'd49);
      @(negedge clk);
      chk("R6 done width", {63'd0, done}, 64'd0);
      chk("R6 output hold", {outL, outR}, exp);
      runBlk(1'b1, VEC[v], 0, res2, edges);
      chk("R4 paired latency", 64'(edges), 64'd33);
      chk("R5 mode agreement", res2, res);
    end

    // R2: rewrite last subkey only; left half shifts by the delta
    runBlk(1'b1, VEC[2], 0, res, edges);
    wr(1'b1, 10'd17, pa[17] ^ 32'hA5A5_0001);
    pa[17] = pa[17] ^ 32'hA5A5_0001;
    runBlk(1'b1, VEC[2], 0, res2, edges);
    chk("R2 subkey write", res2 ^ res, 64'hA5A5_0001_0000_0000);
    // R2: rewrite one table entry and compare with model
    wr(1'b0, {2'd3, 8'h5A}, 32'h0F1E_2D3C);
    sb[3][8'h5A] = 32'h0F1E_2D3C;
    runBlk(1'b0, 64'h1111_2222_3333_445A, 0, res, edges);
    chk("R2 table write", res, encRef(64'h1111_2222_3333_445A));

    // R7: start mid-run is ignored
    exp = encRef(VEC[3]);
    runBlk(1'b0, VEC[3], 10, res, edges);
    chk("R7 busy start result", res, exp);
    chk("R7 busy start latency", 64'(edges), 64'd49);
    begin
      int extra = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R7 no second done", 64'(extra), 64'd0);
    end

    // R9: zero key material exchanges the halves
    loadKeys(32'h1, 1'b1);
    runBlk(1'b0, 64'hCAFE_F00D_1234_5678, 0, res, edges);
    chk("R9 zero keys three-cycle", res, 64'h1234_5678_CAFE_F00D);
    runBlk(1'b1, 64'hCAFE_F00D_1234_5678, 0, res, edges);
    chk("R9 zero keys paired", res, 64'h1234_5678_CAFE_F00D);

    summary();
  end
endmodule